// File: doc/BRIEF.md
# Dual-Mode RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB TFT panel, clocked by the pixel clock. A horizontal counter steps every clock and a vertical counter steps once per line. Each axis is divided into four programmable intervals, in this order: the sync pulse, the back porch, the active window and the front porch. From these counters the block drives a 24-bit pixel bus, an active-high data-enable line and a pair of sync outputs. It raises a request strobe one clock before each visible pixel, so that an upstream source can supply the pixel. It also reports the coordinates of the pixel on the bus and gives a one-cycle pulse at the start of every frame.

A runtime mode input chooses the sync style. In HV mode the two sync lines pulse with a programmable polarity, one per axis. In DE-only mode the same internal timing runs unchanged, but both sync lines stay at their inactive level, and a panel can find line and frame boundaries only from the edges of the data-enable line. The lengths, the polarities and the mode are captured into shadow registers only when the frame wraps, so a change made in the middle of a frame cannot tear the picture.

Top module: `rgbt_timing_gen`

## Requirements
- R1: While reset is asserted, every output is zero: `pix_req`, `de_out`, `rgb_out`, `hsync_out`, `vsync_out`, `x_out`, `y_out` and `sof_out`.
- R2: A line lasts sync+back+active+front clocks, in that order. A frame lasts the sum of the four vertical lengths, counted in lines. Every length is at least 1.
- R3: In HV mode (`mode_de_only`=0), `hsync_out` is at its active level during the horizontal sync clocks of every line and at the inverse level elsewhere. `vsync_out` is at its active level for every clock of the vertical sync lines. A polarity input of 1 means active-high and 0 means active-low.
- R4: In DE-only mode (`mode_de_only`=1), `hsync_out` and `vsync_out` stay at their inactive level (the inverse of their polarity) for the whole frame, while the internal timing is unchanged.
- R5: `de_out` is 1 exactly for the clocks that fall in both the horizontal and the vertical active window. `rgb_out` carries the captured pixel while `de_out` is 1 and is zero otherwise.
- R6: `pix_req` is 1 exactly one clock before each clock in which `de_out` is 1. The value on `pix_in` during a request clock appears on `rgb_out` at the next clock, together with `de_out`.
- R7: While `de_out` is 1, `x_out` and `y_out` give the pixel's column and row counted from 0 within the active window. They are zero while `de_out` is 0.
- R8: `sof_out` is 1 for one clock per frame, on the first clock of the frame (the first sync clock of the first sync line), in both modes.
- R9: The lengths, polarities and mode are captured only at the frame wrap. A change applied in the middle of a frame takes effect from the first clock of the next frame.
- R10: At the first clock edge after reset is released, the configuration is captured and the outputs remain zero. The first clock of the first frame appears on the outputs after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_de_only | input | 1 | 0: HV sync style, 1: DE-only style |
| hsync_pol | input | 1 | Horizontal sync polarity, 1 = active-high |
| vsync_pol | input | 1 | Vertical sync polarity, 1 = active-high |
| h_sync_len | input | 12 | Horizontal sync length in clocks |
| h_back_len | input | 12 | Horizontal back porch in clocks |
| h_act_len | input | 12 | Visible pixels per line |
| h_front_len | input | 12 | Horizontal front porch in clocks |
| v_sync_len | input | 11 | Vertical sync length in lines |
| v_back_len | input | 11 | Vertical back porch in lines |
| v_act_len | input | 11 | Visible lines per frame |
| v_front_len | input | 11 | Vertical front porch in lines |
| pix_in | input | 24 | Pixel from the upstream source |
| pix_req | output | 1 | Requests the pixel for the next clock |
| rgb_out | output | 24 | Pixel bus to the panel |
| de_out | output | 1 | Data enable, active-high |
| hsync_out | output | 1 | Horizontal sync |
| vsync_out | output | 1 | Vertical sync |
| x_out | output | 12 | Column of the pixel on the bus |
| y_out | output | 11 | Row of the pixel on the bus |
| sof_out | output | 1 | One-clock start-of-frame pulse |

## Verification
The bench runs complete frames of two small geometries and compares every output at every clock with values worked out from the clock's position in the frame. The sequence covers both sync polarities, both modes, and a geometry change. Each polarity, mode or geometry change is applied just after a frame begins. A design that reacts at once then differs from one that waits for the wrap, which is what separates R9 from R3 and R4. Driving a pixel pattern that is never zero, including during blanking, shows whether the bus is forced to zero outside the active window. Because the pattern encodes the clock index, any skew of one clock between `pix_req`, `de_out` and `rgb_out` becomes visible.

// File: rtl/rgbt_pkg.sv
package rgbt_pkg;

    typedef enum logic {
        SYNC_HV      = 1'b0,
        SYNC_DE_ONLY = 1'b1
    } sync_mode_e;

endpackage

// File: rtl/rgbt_axis_ctr.sv
module rgbt_axis_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_front,
    output logic [W-1:0] cnt,
    output logic         in_sync,
    output logic         in_act,
    output logic         last,
    output logic [W-1:0] act_pos
);
    localparam int SW = W + 2;

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t           st_d, st_q;
    logic [SW-1:0]  act_start, act_end, total, cnt_w;

    // interval decode
    always_comb begin
        act_start = SW'(len_sync) + SW'(len_back);
        act_end   = act_start + SW'(len_act);
        total     = act_end + SW'(len_front);
        cnt_w     = SW'(st_q.cnt);
        last      = (cnt_w == total - SW'(1));
        in_sync   = (cnt_w < SW'(len_sync));
        in_act    = (cnt_w >= act_start) && (cnt_w < act_end);
        act_pos   = in_act ? W'(cnt_w - act_start) : '0;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = last ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    p_cnt_in_range_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (run && total != '0) |-> (cnt_w < total));

endmodule

// File: rtl/rgbt_cfg_shadow.sv
module rgbt_cfg_shadow
    import rgbt_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          live_de_only,
    input  logic          live_hpol,
    input  logic          live_vpol,
    input  logic [HW-1:0] live_h_sync,
    input  logic [HW-1:0] live_h_back,
    input  logic [HW-1:0] live_h_act,
    input  logic [HW-1:0] live_h_front,
    input  logic [VW-1:0] live_v_sync,
    input  logic [VW-1:0] live_v_back,
    input  logic [VW-1:0] live_v_act,
    input  logic [VW-1:0] live_v_front,
    output sync_mode_e    sh_mode,
    output logic          sh_hpol,
    output logic          sh_vpol,
    output logic [HW-1:0] sh_h_sync,
    output logic [HW-1:0] sh_h_back,
    output logic [HW-1:0] sh_h_act,
    output logic [HW-1:0] sh_h_front,
    output logic [VW-1:0] sh_v_sync,
    output logic [VW-1:0] sh_v_back,
    output logic [VW-1:0] sh_v_act,
    output logic [VW-1:0] sh_v_front
);
    typedef struct packed {
        sync_mode_e    mode;
        logic          hpol;
        logic          vpol;
        logic [HW-1:0] h_sync;
        logic [HW-1:0] h_back;
        logic [HW-1:0] h_act;
        logic [HW-1:0] h_front;
        logic [VW-1:0] v_sync;
        logic [VW-1:0] v_back;
        logic [VW-1:0] v_act;
        logic [VW-1:0] v_front;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.mode    = live_de_only ? SYNC_DE_ONLY : SYNC_HV;
            st_d.hpol    = live_hpol;
            st_d.vpol    = live_vpol;
            st_d.h_sync  = live_h_sync;
            st_d.h_back  = live_h_back;
            st_d.h_act   = live_h_act;
            st_d.h_front = live_h_front;
            st_d.v_sync  = live_v_sync;
            st_d.v_back  = live_v_back;
            st_d.v_act   = live_v_act;
            st_d.v_front = live_v_front;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= SYNC_HV;
            st_q.hpol <= 1'b1;
            st_q.vpol <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_mode    = st_q.mode;
    assign sh_hpol    = st_q.hpol;
    assign sh_vpol    = st_q.vpol;
    assign sh_h_sync  = st_q.h_sync;
    assign sh_h_back  = st_q.h_back;
    assign sh_h_act   = st_q.h_act;
    assign sh_h_front = st_q.h_front;
    assign sh_v_sync  = st_q.v_sync;
    assign sh_v_back  = st_q.v_back;
    assign sh_v_act   = st_q.v_act;
    assign sh_v_front = st_q.v_front;

endmodule

// File: rtl/rgbt_out_stage.sv
module rgbt_out_stage #(
    parameter int DW = 24,
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          de_only,
    input  logic          hpol,
    input  logic          vpol,
    input  logic          h_in_sync,
    input  logic          v_in_sync,
    input  logic          act,
    input  logic [HW-1:0] x_in,
    input  logic [VW-1:0] y_in,
    input  logic          sof_in,
    input  logic [DW-1:0] pix,
    output logic [DW-1:0] rgb,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic [HW-1:0] x,
    output logic [VW-1:0] y,
    output logic          sof
);
    typedef struct packed {
        logic [DW-1:0] rgb;
        logic          de;
        logic          hs;
        logic          vs;
        logic [HW-1:0] x;
        logic [VW-1:0] y;
        logic          sof;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (run) begin
            st_d.de  = act;
            st_d.rgb = act ? pix : '0;
            st_d.x   = act ? x_in : '0;
            st_d.y   = act ? y_in : '0;
            st_d.sof = sof_in;
            if (de_only) begin
                st_d.hs = ~hpol;
                st_d.vs = ~vpol;
            end else begin
                st_d.hs = h_in_sync ? hpol : ~hpol;
                st_d.vs = v_in_sync ? vpol : ~vpol;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgb   = st_q.rgb;
    assign de    = st_q.de;
    assign hsync = st_q.hs;
    assign vsync = st_q.vs;
    assign x     = st_q.x;
    assign y     = st_q.y;
    assign sof   = st_q.sof;

endmodule

// File: rtl/rgbt_timing_gen.sv
module rgbt_timing_gen
    import rgbt_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int H_W    = 12,
    parameter int V_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_de_only,
    input  logic              hsync_pol,
    input  logic              vsync_pol,
    input  logic [H_W-1:0]    h_sync_len,
    input  logic [H_W-1:0]    h_back_len,
    input  logic [H_W-1:0]    h_act_len,
    input  logic [H_W-1:0]    h_front_len,
    input  logic [V_W-1:0]    v_sync_len,
    input  logic [V_W-1:0]    v_back_len,
    input  logic [V_W-1:0]    v_act_len,
    input  logic [V_W-1:0]    v_front_len,
    input  logic [DATA_W-1:0] pix_in,
    output logic              pix_req,
    output logic [DATA_W-1:0] rgb_out,
    output logic              de_out,
    output logic              hsync_out,
    output logic              vsync_out,
    output logic [H_W-1:0]    x_out,
    output logic [V_W-1:0]    y_out,
    output logic              sof_out
);
    typedef struct packed {
        logic run;
    } top_t;

    top_t st_d, st_q;

    sync_mode_e     sh_mode;
    logic           sh_hpol, sh_vpol;
    logic [H_W-1:0] sh_h_sync, sh_h_back, sh_h_act, sh_h_front;
    logic [V_W-1:0] sh_v_sync, sh_v_back, sh_v_act, sh_v_front;

    logic [H_W-1:0] h_cnt, h_pos;
    logic [V_W-1:0] v_cnt, v_pos;
    logic           h_sync_w, h_act_w, h_last;
    logic           v_sync_w, v_act_w, v_last;
    logic           frame_wrap, load_cfg, act_now, sof_now;

    always_comb begin
        st_d     = st_q;
        st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        frame_wrap = st_q.run && h_last && v_last;
        load_cfg   = !st_q.run || frame_wrap;
        act_now    = st_q.run && h_act_w && v_act_w;
        sof_now    = st_q.run && (h_cnt == '0) && (v_cnt == '0);
    end

    assign pix_req = act_now;

    rgbt_cfg_shadow #(.HW(H_W), .VW(V_W)) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load_cfg),
        .live_de_only (mode_de_only),
        .live_hpol    (hsync_pol),
        .live_vpol    (vsync_pol),
        .live_h_sync  (h_sync_len),
        .live_h_back  (h_back_len),
        .live_h_act   (h_act_len),
        .live_h_front (h_front_len),
        .live_v_sync  (v_sync_len),
        .live_v_back  (v_back_len),
        .live_v_act   (v_act_len),
        .live_v_front (v_front_len),
        .sh_mode      (sh_mode),
        .sh_hpol      (sh_hpol),
        .sh_vpol      (sh_vpol),
        .sh_h_sync    (sh_h_sync),
        .sh_h_back    (sh_h_back),
        .sh_h_act     (sh_h_act),
        .sh_h_front   (sh_h_front),
        .sh_v_sync    (sh_v_sync),
        .sh_v_back    (sh_v_back),
        .sh_v_act     (sh_v_act),
        .sh_v_front   (sh_v_front)
    );

    rgbt_axis_ctr #(.W(H_W)) hctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.run),
        .step      (1'b1),
        .len_sync  (sh_h_sync),
        .len_back  (sh_h_back),
        .len_act   (sh_h_act),
        .len_front (sh_h_front),
        .cnt       (h_cnt),
        .in_sync   (h_sync_w),
        .in_act    (h_act_w),
        .last      (h_last),
        .act_pos   (h_pos)
    );

    rgbt_axis_ctr #(.W(V_W)) vctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.run),
        .step      (h_last),
        .len_sync  (sh_v_sync),
        .len_back  (sh_v_back),
        .len_act   (sh_v_act),
        .len_front (sh_v_front),
        .cnt       (v_cnt),
        .in_sync   (v_sync_w),
        .in_act    (v_act_w),
        .last      (v_last),
        .act_pos   (v_pos)
    );

    rgbt_out_stage #(.DW(DATA_W), .HW(H_W), .VW(V_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (st_q.run),
        .de_only   (sh_mode == SYNC_DE_ONLY),
        .hpol      (sh_hpol),
        .vpol      (sh_vpol),
        .h_in_sync (h_sync_w),
        .v_in_sync (v_sync_w),
        .act       (act_now),
        .x_in      (h_pos),
        .y_in      (v_pos),
        .sof_in    (sof_now),
        .pix       (pix_in),
        .rgb       (rgb_out),
        .de        (de_out),
        .hsync     (hsync_out),
        .vsync     (vsync_out),
        .x         (x_out),
        .y         (y_out),
        .sof       (sof_out)
    );

    // a request is followed by enable on the next clock
    p_req_leads_de_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> de_out);

    // no enable without a request one clock earlier
    p_no_req_no_de_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |=> !de_out);

    p_de_only_sync_idle_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && sh_mode == SYNC_DE_ONLY) |=>
            (hsync_out == !$past(sh_hpol)) && (vsync_out == !$past(sh_vpol)));

    p_sof_at_origin_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && sof_now) |=> sof_out && !de_out);

    p_cfg_hold_midframe_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !frame_wrap) |=>
            $stable(sh_mode) && $stable(sh_hpol) && $stable(sh_h_act) && $stable(sh_v_act));

endmodule

// File: tb/rgbt_timing_gen_tb.sv
`timescale 1ns/1ps
module rgbt_timing_gen_tb_top;

    typedef struct {
        int hs, hb, ha, hf;
        int vs, vb, va, vf;
        bit hpol, vpol, de_only;
    } cfg_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_de_only = 1'b0;
    logic        hsync_pol = 1'b1;
    logic        vsync_pol = 1'b1;
    logic [11:0] h_sync_len = '0, h_back_len = '0, h_act_len = '0, h_front_len = '0;
    logic [10:0] v_sync_len = '0, v_back_len = '0, v_act_len = '0, v_front_len = '0;
    logic [23:0] pix_in = '0;
    logic        pix_req, de_out, hsync_out, vsync_out, sof_out;
    logic [23:0] rgb_out;
    logic [11:0] x_out;
    logic [10:0] y_out;

    int n_chk = 0;
    int n_err = 0;
    int frame_bad = 0;
    int frame_idx = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    rgbt_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .mode_de_only(mode_de_only),
        .hsync_pol(hsync_pol), .vsync_pol(vsync_pol),
        .h_sync_len(h_sync_len), .h_back_len(h_back_len),
        .h_act_len(h_act_len), .h_front_len(h_front_len),
        .v_sync_len(v_sync_len), .v_back_len(v_back_len),
        .v_act_len(v_act_len), .v_front_len(v_front_len),
        .pix_in(pix_in), .pix_req(pix_req), .rgb_out(rgb_out),
        .de_out(de_out), .hsync_out(hsync_out), .vsync_out(vsync_out),
        .x_out(x_out), .y_out(y_out), .sof_out(sof_out)
    );

    task automatic chk(input string req, input longint act, input longint exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            frame_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (frame %0d)", req, what, act, exp, frame_idx);
        end
    endtask

    task automatic apply(input cfg_t c);
        h_sync_len   = 12'(c.hs);  h_back_len = 12'(c.hb);
        h_act_len    = 12'(c.ha);  h_front_len = 12'(c.hf);
        v_sync_len   = 11'(c.vs);  v_back_len = 11'(c.vb);
        v_act_len    = 11'(c.va);  v_front_len = 11'(c.vf);
        hsync_pol    = c.hpol;
        vsync_pol    = c.vpol;
        mode_de_only = c.de_only;
    endtask

    function automatic logic [23:0] pat(input int p);
        return {8'(8'hC3 ^ frame_idx), 16'(p)};
    endfunction

    function automatic bit is_act(input cfg_t c, input int p);
        int ht = c.hs + c.hb + c.ha + c.hf;
        int h = p % ht;
        int v = p / ht;
        return (h >= c.hs + c.hb) && (h < c.hs + c.hb + c.ha) &&
               (v >= c.vs + c.vb) && (v < c.vs + c.vb + c.va);
    endfunction

    // stands at the negedge where the counter stage holds position 0 of the frame
    task automatic run_frame(input cfg_t cur, input cfg_t nxt, input string ftag);
        int ht = cur.hs + cur.hb + cur.ha + cur.hf;
        int vt = cur.vs + cur.vb + cur.va + cur.vf;
        int de_cnt = 0;
        int sof_cnt = 0;
        string stag = cur.de_only ? "R4" : "R3";
        frame_bad = 0;
        for (int p = 0; p < ht * vt; p++) begin
            pix_in = pat(p);
            if (p == 1) apply(nxt);
            chk("R6", pix_req, is_act(cur, p), "pix_req");
            @(posedge clk);
            @(negedge clk);
            begin
                int h = p % ht;
                int v = p / ht;
                bit a = is_act(cur, p);
                bit ehs = cur.de_only ? !cur.hpol : ((h < cur.hs) ? cur.hpol : !cur.hpol);
                bit evs = cur.de_only ? !cur.vpol : ((v < cur.vs) ? cur.vpol : !cur.vpol);
                chk("R5", de_out, a, "de_out");
                chk("R5", rgb_out, a ? pat(p) : 24'h0, "rgb_out");
                chk(stag, hsync_out, ehs, "hsync_out");
                chk(stag, vsync_out, evs, "vsync_out");
                chk("R7", x_out, a ? h - cur.hs - cur.hb : 0, "x_out");
                chk("R7", y_out, a ? v - cur.vs - cur.vb : 0, "y_out");
                chk("R8", sof_out, p == 0, "sof_out");
                de_cnt += int'(de_out);
                sof_cnt += int'(sof_out);
            end
        end
        chk("R2", de_cnt, cur.ha * cur.va, "enabled clocks per frame");
        chk("R8", sof_cnt, 1, "start pulses per frame");
        chk(ftag, frame_bad, 0, "frame matched captured configuration");
        frame_idx++;
    endtask

    initial begin
        cfg_t a, a_lo, a_de, b, b_de;
        a    = '{hs:2, hb:3, ha:6, hf:2, vs:1, vb:2, va:3, vf:1, hpol:1'b1, vpol:1'b1, de_only:1'b0};
        a_lo = a;    a_lo.hpol = 1'b0; a_lo.vpol = 1'b0;
        a_de = a_lo; a_de.de_only = 1'b1;
        b    = '{hs:1, hb:1, ha:4, hf:3, vs:2, vb:1, va:2, vf:2, hpol:1'b1, vpol:1'b0, de_only:1'b0};
        b_de = b;    b_de.de_only = 1'b1;

        apply(a);
        pix_in = 24'hFFFFFF;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", pix_req, 0, "pix_req in reset");
        chk("R1", de_out, 0, "de_out in reset");
        chk("R1", rgb_out, 0, "rgb_out in reset");
        chk("R1", hsync_out, 0, "hsync_out in reset");
        chk("R1", vsync_out, 0, "vsync_out in reset");
        chk("R1", {x_out, y_out, sof_out}, 0, "coords/sof in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R10: the first edge only captures the configuration
        chk("R10", {de_out, hsync_out, vsync_out, sof_out}, 0, "outputs after first edge");
        chk("R10", rgb_out, 0, "rgb after first edge");

        run_frame(a,    a_lo, "R10");
        run_frame(a_lo, a_de, "R9");
        run_frame(a_de, b,    "R9");
        run_frame(b,    b_de, "R9");
        run_frame(b_de, a,    "R9");
        run_frame(a,    a,    "R9");

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule